// File: doc/BRIEF.md
# GPIO Bank with Radio-State Output Selection

This block is a general-purpose I/O bank whose pin outputs follow the radio's live transmit/receive condition. Each pin is configured to hold a static level or to track the radio state. For a tracking pin, the output is taken from one of four value registers. The register used is picked from the rx-active and tx-active status inputs: idle, receive-only, transmit-only or full-duplex.

Configuration arrives over a plain strobe/address/data settings bus. A direction register drives the pad output enables. A readback word gives, per pin, either the level being driven (output pins) or the synchronized pad level (input pins).

The pad tristate cells, any host-side shadow copies and the bus fabric sit outside this block.

Top module: `gpio_atr_bank`

## Requirements
- R1: While and right after reset, every configuration register is zero, so padOut is 0, padOe is 0 and rdData is 0 while padIn is 0.
- R2: A write with setStb high loads setData into a register chosen by setAddr relative to BASE_ADDR: +0 idle values, +1 receive-only values, +2 transmit-only values, +3 full-duplex values, +4 static-select mask, +5 direction mask. Any other address changes nothing.
- R3: A pin whose static-select bit is 0 drives the bit of the value register picked by the radio state. The state is decoded as follows: {txActive,rxActive}=00 gives idle, 01 gives receive-only, 10 gives transmit-only and 11 gives full-duplex.
- R4: A pin whose static-select bit is 1 drives its idle-register bit in every radio state.
- R5: padOut is registered. A change of rxActive/txActive sampled at a clock edge appears on padOut at that edge, so it is visible one cycle after the inputs change. A register write appears one edge after the write edge.
- R6: padOe equals the direction register, with 1 meaning output, and it changes only after a write to the direction address.
- R7: For a pin whose direction bit is 1, the rdData bit equals the padOut bit.
- R8: For a pin whose direction bit is 0, the rdData bit equals padIn as sampled two clock edges earlier, through a two-flop synchronizer.
- R9: When setStb is low, setAddr and setData have no effect, even at a valid register address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setStb | input | 1 | Settings write strobe |
| setAddr | input | ADDR_W | Settings write address |
| setData | input | WIDTH | Settings write data |
| rxActive | input | 1 | Radio receive active |
| txActive | input | 1 | Radio transmit active |
| padIn | input | WIDTH | Pad input levels (asynchronous) |
| padOut | output | WIDTH | Pad output values |
| padOe | output | WIDTH | Pad output enables, 1 = drive |
| rdData | output | WIDTH | Readback word |

## Verification
The bench builds the bank with WIDTH at 32 and ADDR_W at 8, and moves BASE_ADDR to 0x40. With the base address away from zero, a decoder that ignores the base or mis-adds an offset lands on the wrong register. Writes to 0x00 and to the addresses just below and just above the register window then show up as changes on padOut or padOe. The full 32-bit width lets the test patterns split static and tracking pins, and output and input pins, across both halves of the word. This way, swapped masks or swapped state registers give visible mismatches.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX   = 2'd2,
    ST_FDX  = 2'd3
  } atrState_e;

  localparam int NUM_STATES = 4;
  localparam int NUM_REGS   = 6;

  // register offsets from the block base address
  localparam int OFS_IDLE   = 0;
  localparam int OFS_RX     = 1;
  localparam int OFS_TX     = 2;
  localparam int OFS_FDX    = 3;
  localparam int OFS_STATIC = 4;
  localparam int OFS_DIR    = 5;

  typedef struct packed {
    logic wrDir;
    logic wrStatic;
    logic wrFdx;
    logic wrTx;
    logic wrRx;
    logic wrIdle;
  } cfgStrobe_t;

endpackage

// File: rtl/gpio_atr_ctrl.sv
module gpio_atr_ctrl
  import gpio_atr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              setStb,
  input  logic [ADDR_W-1:0] setAddr,
  input  logic              rxActive,
  input  logic              txActive,
  output cfgStrobe_t        strobes,
  output atrState_e         atrState
);

  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR + ADDR_W'(i);
    assign hit[i] = setStb && (setAddr == MY_ADDR);
  end

  always_comb begin
    strobes.wrIdle   = hit[OFS_IDLE];
    strobes.wrRx     = hit[OFS_RX];
    strobes.wrTx     = hit[OFS_TX];
    strobes.wrFdx    = hit[OFS_FDX];
    strobes.wrStatic = hit[OFS_STATIC];
    strobes.wrDir    = hit[OFS_DIR];
  end

  always_comb begin
    unique case ({txActive, rxActive})
      2'b00:   atrState = ST_IDLE;
      2'b01:   atrState = ST_RX;
      2'b10:   atrState = ST_TX;
      default: atrState = ST_FDX;
    endcase
  end

endmodule

// File: rtl/gpio_atr_dp.sv
module gpio_atr_dp
  import gpio_atr_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  cfgStrobe_t       strobes,
  input  logic [WIDTH-1:0] setData,
  input  atrState_e        atrState,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] rdData
);

  logic [NUM_STATES-1:0]            wrVal;
  logic [NUM_STATES-1:0][WIDTH-1:0] valArr;
  logic [WIDTH-1:0]                 staticMask;
  logic [WIDTH-1:0]                 dirMask;
  logic [WIDTH-1:0]                 outQ;
  logic [WIDTH-1:0]                 outNext;
  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncQ;

  assign wrVal = {strobes.wrFdx, strobes.wrTx, strobes.wrRx, strobes.wrIdle};

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_val
    logic [WIDTH-1:0] valQ;
    always_ff @(posedge clk) begin
      if (rst)           valQ <= '0;
      else if (wrVal[s]) valQ <= setData;
    end
    assign valArr[s] = valQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      staticMask <= '0;
      dirMask    <= '0;
    end else begin
      if (strobes.wrStatic) staticMask <= setData;
      if (strobes.wrDir)    dirMask    <= setData;
    end
  end

  always_comb begin
    outNext = (staticMask & valArr[ST_IDLE]) | (~staticMask & valArr[atrState]);
  end

  always_ff @(posedge clk) begin
    if (rst) outQ <= '0;
    else     outQ <= outNext;
  end

  for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst)         syncQ[k] <= '0;
      else if (k == 0) syncQ[k] <= padIn;
      else             syncQ[k] <= syncQ[(k == 0) ? 0 : k-1];
    end
  end

  assign padOut = outQ;
  assign padOe  = dirMask;
  assign rdData = (dirMask & outQ) | (~dirMask & syncQ[SYNC_STAGES-1]);

endmodule

// File: rtl/gpio_atr_bank.sv
module gpio_atr_bank
  import gpio_atr_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              setStb,
  input  logic [ADDR_W-1:0] setAddr,
  input  logic [WIDTH-1:0]  setData,
  input  logic              rxActive,
  input  logic              txActive,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  rdData
);

  cfgStrobe_t strobes;
  atrState_e  atrState;

  gpio_atr_ctrl #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .setStb  (setStb),
    .setAddr (setAddr),
    .rxActive(rxActive),
    .txActive(txActive),
    .strobes (strobes),
    .atrState(atrState)
  );

  gpio_atr_dp #(
    .WIDTH      (WIDTH),
    .SYNC_STAGES(2)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .setData (setData),
    .atrState(atrState),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .rdData  (rdData)
  );

endmodule

// File: rtl/gpio_atr_bank_chk.sv
module gpio_atr_bank_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             setStb,
  input logic             rxActive,
  input logic             txActive,
  input logic [WIDTH-1:0] padIn,
  input logic [WIDTH-1:0] padOut,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] rdData
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (padOut == '0 && padOe == '0)); // R1

  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$past(setStb) |-> $stable(padOe)); // R6

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(setStb) && !$past(setStb, 2) &&
     $past(rxActive) == $past(rxActive, 2) && $past(txActive) == $past(txActive, 2))
    |-> $stable(padOut)); // R5

  AST_RB_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    ((rdData ^ padOut) & padOe) == '0); // R7

  AST_RB_INPUTS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (((rdData ^ $past(padIn, 2)) & ~padOe) == '0)); // R8

endmodule

bind gpio_atr_bank gpio_atr_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .setStb  (setStb),
  .rxActive(rxActive),
  .txActive(txActive),
  .padIn   (padIn),
  .padOut  (padOut),
  .padOe   (padOe),
  .rdData  (rdData)
);

// File: tb/tb_gpio_atr_bank.sv
module tb_gpio_atr_bank;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] BASE = 8'h40;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              setStb = 1'b0;
  logic [ADDR_W-1:0] setAddr = '0;
  logic [WIDTH-1:0]  setData = '0;
  logic              rxActive = 1'b0;
  logic              txActive = 1'b0;
  logic [WIDTH-1:0]  padIn = '0;
  logic [WIDTH-1:0]  padOut, padOe, rdData;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // bench-side model of the configuration
  logic [WIDTH-1:0] mVal [4];
  logic [WIDTH-1:0] mStatic = '0;
  logic [WIDTH-1:0] mDir = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_atr_bank #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rst(rst), .setStb(setStb), .setAddr(setAddr), .setData(setData),
    .rxActive(rxActive), .txActive(txActive), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .rdData(rdData)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] expOut(input logic rx, input logic tx);
    int idx = {tx, rx};
    return (mStatic & mVal[0]) | (~mStatic & mVal[idx]);
  endfunction

  task automatic writeReg(input int ofs, input logic [WIDTH-1:0] d);
    @(negedge clk);
    setStb = 1'b1; setAddr = BASE + ADDR_W'(ofs); setData = d;
    @(negedge clk);
    setStb = 1'b0;
    if (ofs < 4) mVal[ofs] = d;
    else if (ofs == 4) mStatic = d;
    else if (ofs == 5) mDir = d;
    @(negedge clk); // output register catches up
  endtask

  task automatic setState(input logic rx, input logic tx);
    @(negedge clk);
    rxActive = rx; txActive = tx;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 padOut", padOut, '0);
    check("R1 padOe", padOe, '0);
    check("R1 rdData", rdData, '0);
  endtask

  task automatic testStates();
    writeReg(5, 32'hFFFF_FFFF);
    check("R6 oe all", padOe, 32'hFFFF_FFFF);
    writeReg(0, 32'hA5A5_0001);
    writeReg(1, 32'h1234_5678);
    writeReg(2, 32'h0F0F_F0F0);
    writeReg(3, 32'hDEAD_BEEF);
    writeReg(4, 32'h0);
    for (int s = 0; s < 4; s++) begin
      setState(s[0], s[1]);
      check("R3 state sel", padOut, expOut(s[0], s[1]));
      check("R7 rb out", rdData, expOut(s[0], s[1]));
    end
  endtask

  task automatic testLatency();
    setState(1'b0, 1'b0);
    @(negedge clk);
    rxActive = 1'b1;
    #1;
    check("R5 before edge", padOut, 32'hA5A5_0001);
    @(negedge clk);
    check("R5 after edge", padOut, 32'h1234_5678);
    @(negedge clk);
    setStb = 1'b1; setAddr = BASE + 8'd1; setData = 32'h7777_0000;
    @(negedge clk);
    setStb = 1'b0; mVal[1] = 32'h7777_0000;
    check("R5 write not yet", padOut, 32'h1234_5678);
    @(negedge clk);
    check("R5 write seen", padOut, 32'h7777_0000);
  endtask

  task automatic testStatic();
    writeReg(4, 32'hFFFF_0000);
    for (int s = 0; s < 4; s++) begin
      setState(s[0], s[1]);
      check("R4 static mix", padOut, expOut(s[0], s[1]));
      check("R4 static upper", padOut & 32'hFFFF_0000, mVal[0] & 32'hFFFF_0000);
    end
  endtask

  task automatic testReadback();
    writeReg(5, 32'h0000_FFFF);
    check("R6 oe half", padOe, 32'h0000_FFFF);
    @(negedge clk);
    padIn = 32'hC3C3_AAAA;
    @(negedge clk);
    check("R8 one edge", rdData & 32'hFFFF_0000, 32'h0);
    @(negedge clk);
    check("R8 two edges", rdData & 32'hFFFF_0000, 32'hC3C3_0000);
    check("R7 out half", rdData & 32'h0000_FFFF, padOut & 32'h0000_FFFF);
  endtask

  task automatic testIgnored();
    logic [WIDTH-1:0] oldOut, oldOe;
    setState(1'b1, 1'b1);
    oldOut = padOut; oldOe = padOe;
    writeReg(6, 32'h5555_5555);     // just above window
    writeReg(-1, 32'h5555_5555);    // just below window
    @(negedge clk);
    setStb = 1'b1; setAddr = 8'h00 + 8'd5; setData = 32'hFFFF_FFFF;
    @(negedge clk);
    setStb = 1'b0;
    @(negedge clk);
    check("R2 unused addr out", padOut, oldOut);
    check("R2 unused addr oe", padOe, oldOe);
    setStb = 1'b0; setAddr = BASE + 8'd5; setData = 32'hFFFF_FFFF;
    @(negedge clk);
    setAddr = BASE + 8'd3; setData = 32'h0;
    @(negedge clk);
    @(negedge clk);
    check("R9 no strobe oe", padOe, oldOe);
    check("R9 no strobe out", padOut, oldOut);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mVal[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testStates();
    testLatency();
    testStatic();
    testReadback();
    testIgnored();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule